// File: doc/BRIEF.md
# Wi-Fi/Bluetooth Coexistence Arbiter

This block decides, slot by slot, whether an external Bluetooth controller may use the shared 2.4 GHz medium or must yield to the local WLAN engine. The Bluetooth side raises a request line for each transmit or receive slot it wants. In the three-wire handshake it also supplies a priority line. The arbiter answers on a single deny line: high means the slot is blocked.

The local WLAN engine supplies two synchronous hints: whether it is busy and whether its current traffic is high priority. A mode bit selects the two-wire handshake, which has no priority line, or the three-wire handshake. A bypass bit suspends arbitration. In bypass, software steers the antenna switch directly and no slot is ever denied.

The Bluetooth lines are asynchronous and pass through two-stage synchronizers. A verdict is taken once, at the synchronized rising edge of the request. It is then held until the request falls, so the deny line never changes in the middle of a slot.

Top module: `coex_arbiter`

## Requirements
- R1: While reset is high and on the first edge after it, `wl_deny_o` and `ant_sw_o` are 0.
- R2: With `cfg_mode_i`=0 (two-wire) and no bypass, a new request is denied exactly when `wl_active_i` is 1, and `bt_pri_i` has no effect. The verdict appears on the third rising clock edge after `bt_req_i` rises.
- R3: With `cfg_mode_i`=1 (three-wire), a request with `bt_pri_i`=0 is denied exactly when `wl_active_i` is 1.
- R4: With `cfg_mode_i`=1, a request with `bt_pri_i`=1 is denied only when both `wl_active_i` and `wl_hipri_i` are 1.
- R5: While the request stays high and bypass is off, `wl_deny_o` keeps the verdict from the rising edge. Changes on `wl_active_i`, `wl_hipri_i`, `bt_pri_i` or `cfg_mode_i` during the slot do not alter it.
- R6: When `bt_req_i` falls, `wl_deny_o` stays at its verdict through the second edge after the fall and is 0 after the third. It is 0 whenever no request is seen.
- R7: While `cfg_bypass_i` is 1, `wl_deny_o` is 0 and `ant_sw_o` equals `cfg_ant_bt_i` from the edge after each change.
- R8: Outside bypass, `ant_sw_o` is 1 (antenna to Bluetooth) exactly while a granted slot is in progress. It is never 1 together with `wl_deny_o`.
- R9: A slot that was in progress while bypass was on counts as granted when bypass is left. `wl_deny_o` stays 0 and `ant_sw_o` is 1 until the request falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode_i | input | 1 | 0 = two-wire handshake, 1 = three-wire handshake |
| cfg_bypass_i | input | 1 | 1 = arbitration suspended, antenna driven by `cfg_ant_bt_i` |
| cfg_ant_bt_i | input | 1 | Antenna selection in bypass (1 = Bluetooth) |
| bt_req_i | input | 1 | Asynchronous Bluetooth slot request |
| bt_pri_i | input | 1 | Asynchronous Bluetooth slot priority (1 = high) |
| wl_active_i | input | 1 | WLAN engine is using the medium |
| wl_hipri_i | input | 1 | WLAN traffic is high priority |
| wl_deny_o | output | 1 | 1 = Bluetooth request denied, slot blocked |
| ant_sw_o | output | 1 | Antenna switch control (1 = Bluetooth) |

## Verification
The two functions that can land on the same clock edge are the entry into bypass and the synchronized rising edge of a request. The second can also meet the end of bypass while a slot is in progress.

The bench raises the request and then, two cycles later, sets bypass while the WLAN engine is active. Both changes therefore act on one edge. It then expects no deny at any point and an antenna that follows the bypass selection.

A second sequence enters bypass during a denied slot and then leaves it before the request drops. The bench judges that slot as granted, expecting deny at 0 and the antenna at Bluetooth until the request falls.

// File: rtl/coex_pkg.sv
package coex_pkg;

  typedef enum logic {
    HS_TWO_WIRE   = 1'b0,
    HS_THREE_WIRE = 1'b1
  } hs_mode_e;

  localparam int BT_LINES = 2;
  localparam int BT_REQ_BIT = 0;
  localparam int BT_PRI_BIT = 1;

endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/coex_policy.sv
module coex_policy
  import coex_pkg::*;
(
  input  hs_mode_e mode_i,
  input  logic     bt_hipri_i,
  input  logic     wl_active_i,
  input  logic     wl_hipri_i,
  output logic     deny_o
);

  always_comb begin
    unique case (mode_i)
      HS_THREE_WIRE: begin
        if (bt_hipri_i) deny_o = wl_active_i & wl_hipri_i;
        else            deny_o = wl_active_i;
      end
      default:          deny_o = wl_active_i;
    endcase
  end

endmodule

// File: rtl/coex_slot_ctrl.sv
module coex_slot_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_s_i,
  input  logic bypass_i,
  input  logic ant_bt_i,
  input  logic verdict_i,
  output logic deny_o,
  output logic ant_o
);

  logic req_q;
  logic slot_q;
  logic rise;
  logic deny_n;
  logic slot_n;
  logic ant_n;

  assign rise = req_s_i & ~req_q;

  always_comb begin
    slot_n = slot_q;
    deny_n = deny_o;
    if (rise)          slot_n = 1'b1;
    else if (!req_s_i) slot_n = 1'b0;

    if (bypass_i)      deny_n = 1'b0;
    else if (rise)     deny_n = verdict_i;
    else if (!req_s_i) deny_n = 1'b0;

    ant_n = bypass_i ? ant_bt_i : (slot_n & ~deny_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      slot_q <= 1'b0;
      deny_o <= 1'b0;
      ant_o  <= 1'b0;
    end else begin
      req_q  <= req_s_i;
      slot_q <= slot_n;
      deny_o <= deny_n;
      ant_o  <= ant_n;
    end
  end

endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_mode_i,
  input  logic cfg_bypass_i,
  input  logic cfg_ant_bt_i,
  input  logic bt_req_i,
  input  logic bt_pri_i,
  input  logic wl_active_i,
  input  logic wl_hipri_i,
  output logic wl_deny_o,
  output logic ant_sw_o
);

  logic [BT_LINES-1:0] bt_async;
  logic [BT_LINES-1:0] bt_sync;
  logic                req_sync;
  logic                pri_sync;
  logic                verdict;

  assign bt_async[BT_REQ_BIT] = bt_req_i;
  assign bt_async[BT_PRI_BIT] = bt_pri_i;

  coex_sync #(
    .WIDTH  (BT_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (bt_async),
    .sync_o  (bt_sync)
  );

  assign req_sync = bt_sync[BT_REQ_BIT];
  assign pri_sync = bt_sync[BT_PRI_BIT];

  coex_policy u_policy (
    .mode_i      (hs_mode_e'(cfg_mode_i)),
    .bt_hipri_i  (pri_sync),
    .wl_active_i (wl_active_i),
    .wl_hipri_i  (wl_hipri_i),
    .deny_o      (verdict)
  );

  coex_slot_ctrl u_slot (
    .clk       (clk),
    .rst       (rst),
    .req_s_i   (req_sync),
    .bypass_i  (cfg_bypass_i),
    .ant_bt_i  (cfg_ant_bt_i),
    .verdict_i (verdict),
    .deny_o    (wl_deny_o),
    .ant_o     (ant_sw_o)
  );

endmodule

// File: rtl/coex_arbiter_chk.sv
module coex_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic cfg_mode_i,
  input logic cfg_bypass_i,
  input logic cfg_ant_bt_i,
  input logic wl_active_i,
  input logic wl_hipri_i,
  input logic req_s,
  input logic pri_s,
  input logic wl_deny_o,
  input logic ant_sw_o
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wl_deny_o && !ant_sw_o));

  p_two_wire_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    (req_s && !$past(req_s) && !cfg_bypass_i && !cfg_mode_i)
      |=> (wl_deny_o == $past(wl_active_i)));

  p_three_wire_normal_r3: assert property (@(posedge clk) disable iff (rst)
    (req_s && !$past(req_s) && !cfg_bypass_i && cfg_mode_i && !pri_s)
      |=> (wl_deny_o == $past(wl_active_i)));

  p_three_wire_high_r4: assert property (@(posedge clk) disable iff (rst)
    (req_s && !$past(req_s) && !cfg_bypass_i && cfg_mode_i && pri_s)
      |=> (wl_deny_o == $past(wl_active_i && wl_hipri_i)));

  p_slot_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (req_s && $past(req_s) && !cfg_bypass_i) |=> $stable(wl_deny_o));

  p_idle_release_r6: assert property (@(posedge clk) disable iff (rst)
    !req_s |=> !wl_deny_o);

  p_bypass_drive_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass_i |=> (!wl_deny_o && (ant_sw_o == $past(cfg_ant_bt_i))));

  p_ant_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(ant_sw_o && wl_deny_o));

endmodule

bind coex_arbiter coex_arbiter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_mode_i   (cfg_mode_i),
  .cfg_bypass_i (cfg_bypass_i),
  .cfg_ant_bt_i (cfg_ant_bt_i),
  .wl_active_i  (wl_active_i),
  .wl_hipri_i   (wl_hipri_i),
  .req_s        (req_sync),
  .pri_s        (pri_sync),
  .wl_deny_o    (wl_deny_o),
  .ant_sw_o     (ant_sw_o)
);

// File: tb/coex_arbiter_tb_top.sv
`timescale 1ns/1ps
module coex_arbiter_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode_i = 1'b0;
  logic cfg_bypass_i = 1'b0;
  logic cfg_ant_bt_i = 1'b0;
  logic bt_req_i = 1'b0;
  logic bt_pri_i = 1'b0;
  logic wl_active_i = 1'b0;
  logic wl_hipri_i = 1'b0;
  logic wl_deny_o;
  logic ant_sw_o;

  always #10 clk = ~clk;

  coex_arbiter dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_bypass_i (cfg_bypass_i),
    .cfg_ant_bt_i (cfg_ant_bt_i),
    .bt_req_i     (bt_req_i),
    .bt_pri_i     (bt_pri_i),
    .wl_active_i  (wl_active_i),
    .wl_hipri_i   (wl_hipri_i),
    .wl_deny_o    (wl_deny_o),
    .ant_sw_o     (ant_sw_o)
  );

  typedef struct {
    int    due;
    logic  deny;
    logic  ant;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   cycle = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always @(posedge clk) cycle++;

  task automatic push(input int delay, input logic deny, input logic ant, input string tag);
    exp_t e;
    e.due = cycle + delay;
    e.deny = deny;
    e.ant = ant;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares at the falling edge of the due cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cycle) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (e.due != cycle || wl_deny_o !== e.deny || ant_sw_o !== e.ant) begin
        failures++;
        $display("FAIL %s: cycle %0d deny=%b ant=%b expected deny=%b ant=%b (due %0d)",
                 e.tag, cycle, wl_deny_o, ant_sw_o, e.deny, e.ant, e.due);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One slot; the verdict is checked, disturbed mid-slot, then released
  task automatic run_slot(input logic mode, input logic pri, input logic wla,
                          input logic wlh, input logic exp_deny, input string tag);
    @(negedge clk);
    cfg_mode_i = mode;
    bt_pri_i = pri;
    wl_active_i = wla;
    wl_hipri_i = wlh;
    bt_req_i = 1'b1;
    push(3, exp_deny, !exp_deny, tag);
    idle(4);
    wl_active_i = !wla;
    wl_hipri_i = !wlh;
    bt_pri_i = !pri;
    cfg_mode_i = !mode;
    push(3, exp_deny, !exp_deny, "R5 hold");
    idle(4);
    bt_req_i = 1'b0;
    push(2, exp_deny, !exp_deny, "R6 held until sync");
    push(3, 1'b0, 1'b0, "R6 released");
    idle(5);
  endtask

  initial begin
    idle(3);
    push(0, 1'b0, 1'b0, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    push(1, 1'b0, 1'b0, "R1 after reset");
    idle(3);

    // two-wire: priority ignored
    run_slot(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R2 busy hi-pri bt");
    run_slot(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 idle wlan");
    run_slot(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2 busy normal bt");
    // three-wire, normal priority
    run_slot(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3 busy");
    run_slot(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 idle");
    // three-wire, high priority
    run_slot(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 bt wins");
    run_slot(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 wlan hi wins");
    run_slot(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 wlan idle");

    // bypass drive of antenna with no request
    @(negedge clk);
    cfg_bypass_i = 1'b1;
    cfg_ant_bt_i = 1'b1;
    push(1, 1'b0, 1'b1, "R7 bypass ant bt");
    idle(2);
    cfg_ant_bt_i = 1'b0;
    push(1, 1'b0, 1'b0, "R7 bypass ant wlan");
    idle(2);
    cfg_bypass_i = 1'b0;
    idle(3);

    // request rise and bypass entry on the same edge
    @(negedge clk);
    cfg_mode_i = 1'b0;
    wl_active_i = 1'b1;
    bt_req_i = 1'b1;
    idle(2);
    cfg_bypass_i = 1'b1;
    cfg_ant_bt_i = 1'b0;
    push(1, 1'b0, 1'b0, "R7 rise with bypass");
    idle(3);
    cfg_ant_bt_i = 1'b1;
    push(1, 1'b0, 1'b1, "R7 bypass in slot");
    idle(2);
    cfg_bypass_i = 1'b0;
    cfg_ant_bt_i = 1'b0;
    push(1, 1'b0, 1'b1, "R9 leave bypass granted");
    idle(3);
    bt_req_i = 1'b0;
    push(3, 1'b0, 1'b0, "R9 slot ends");
    idle(5);

    // denied slot, bypass mid-slot, leave bypass before release
    @(negedge clk);
    wl_active_i = 1'b1;
    bt_req_i = 1'b1;
    push(3, 1'b1, 1'b0, "R8 denied slot ant wlan");
    idle(4);
    cfg_bypass_i = 1'b1;
    cfg_ant_bt_i = 1'b0;
    push(1, 1'b0, 1'b0, "R7 bypass clears deny");
    idle(2);
    cfg_bypass_i = 1'b0;
    push(1, 1'b0, 1'b1, "R9 granted after bypass");
    idle(3);
    bt_req_i = 1'b0;
    wl_active_i = 1'b0;
    push(3, 1'b0, 1'b0, "R9 release");
    idle(6);

    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d pending items, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule